// File: doc/BRIEF.md
# Three-Level Trap Delegation Resolver

This block decides which privilege level services a trap in a hart that supports guest virtualization. For every trap it is told the cause code, whether the trap is an interrupt, the privilege level the hart was running at and whether the hart was inside a guest (the virtualization bit). It answers with the level that takes the trap (machine, hypervisor-supervisor or guest-supervisor) and the cause value that the handler at that level must see in its cause register.

The block holds four delegation registers: machine exception and interrupt delegation, and hypervisor exception and interrupt delegation. A trap first passes the machine stage. Only if that stage hands it down, and only if the trap was taken inside a guest, is the hypervisor stage consulted. The hypervisor registers have a fixed policy of writable bits, and the bits outside that policy always read zero. Guest-supervisor interrupts handed to the guest are renumbered onto the plain supervisor numbers, so the guest kernel sees an ordinary supervisor world.

A trap request is presented for one cycle with `trap_valid`, and the result appears on the next clock edge with `res_valid` high for one cycle. The register write port takes effect on the clock edge, and the read port is combinational.

Top module: `trap_deleg_resolver`

## Requirements
- R1: A trap taken at privilege level 3 (machine) or the reserved level 2 always targets machine mode (`res_mode` = 3) with the cause code unchanged, whatever the delegation registers and the V bit hold.
- R2: A trap taken with V=0 at level 0 (user) or 1 (supervisor) targets HS (`res_mode` = 1) when the machine delegation bit indexed by the cause code is set, and machine mode otherwise. Exceptions use register select 0 and interrupts use select 1. It never targets VS (`res_mode` = 2).
- R3: A trap taken with V=1 at level 0 or 1 targets machine mode if the machine stage keeps it. It targets HS if the machine stage delegates it and the hypervisor bit is clear (select 2 for exceptions, select 3 for interrupts). It targets VS if both stages delegate it.
- R4: A hypervisor delegation bit has no effect unless the machine delegation bit for the same cause is also set.
- R5: In the hypervisor exception register (select 2) only bits 0–8, 12, 13, 15, 18 and 19 accept writes. Bit 0 is writable because the default instruction alignment is 32 bits. All other bits read zero.
- R6: In the hypervisor interrupt register (select 3) only bits 2, 6 and 10 accept writes. All other bits read zero.
- R7: Both machine delegation registers (selects 0 and 1) accept every bit written to them.
- R8: An interrupt delivered to VS reports a cause one lower than its own: 10 is reported as 9, 6 as 5 and 2 as 1. An interrupt delivered to HS or machine mode keeps its code.
- R9: An exception delivered to VS keeps its cause code, and `res_irq` always echoes the interrupt flag of the request.
- R10: After reset all four registers read zero, `res_valid` is 0 and `res_mode` is 3. A request produces `res_valid` = 1 exactly one cycle later, and `res_valid` is 0 in every cycle that does not follow a request.
- R11: A cause code at or above the register width (64) is never delegated and targets machine mode.
- R12: A write changes only the register its select names. Without a write, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dw_en | input | 1 | Write strobe for a delegation register |
| dw_sel | input | 2 | Register select: 0 machine exc, 1 machine irq, 2 hyp exc, 3 hyp irq |
| dw_data | input | XLEN | Write data, masked by the register's writable bits |
| rd_sel | input | 2 | Read select, same encoding as `dw_sel` |
| rd_data | output | XLEN | Contents of the selected register |
| trap_valid | input | 1 | A trap request is present this cycle |
| trap_irq | input | 1 | 1 for an interrupt, 0 for an exception |
| trap_code | input | 8 | Cause code of the trap |
| cur_priv | input | 2 | Level the trap was taken in: 0 U, 1 S, 2 reserved, 3 M |
| cur_virt | input | 1 | Virtualization bit at the time of the trap |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_mode | output | 2 | Target: 1 HS, 2 VS, 3 M |
| res_irq | output | 1 | Interrupt flag of the resolved trap |
| res_code | output | 8 | Cause value for the target's cause register |

## Verification
The bench targets the places where the stages interact. A hypervisor bit set without its machine bit must leave the trap in machine mode, and a design that consulted the stages independently would hand it to the guest. Guest-page-fault and environment-call causes are delegated through the machine stage with the hypervisor register written all ones. A design with a wrong writable mask would let them reach VS. A wrong mask also shows up in the readback of all-ones writes. Interrupt 9 reaches HS while 10, 6 and 2 reach VS renumbered. A design that renumbered on the wrong path, or not at all, reports the raw code. Machine-level traps with the V bit set, and codes of 64 and above, must stay in machine mode, and a design without these guards would index past the register.

// File: rtl/trap_deleg_pkg.sv
`timescale 1ns/1ps
package trap_deleg_pkg;

    localparam int CODE_W   = 8;
    localparam int NUM_DREG = 4;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        TGT_HS = 2'd1,
        TGT_VS = 2'd2,
        TGT_M  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        SEL_MEXC = 2'd0,
        SEL_MIRQ = 2'd1,
        SEL_HEXC = 2'd2,
        SEL_HIRQ = 2'd3
    } dsel_e;

    typedef struct packed {
        logic  valid;
        tgt_e  mode;
        logic  irq;
        code_t code;
    } trap_res_t;

    // Writable bits of the hypervisor exception register.
    function automatic logic [63:0] hyp_exc_mask(input int ialign);
        logic [63:0] m;
        m = '0;
        for (int b = 1; b <= 8; b++) m[b] = 1'b1;
        m[12] = 1'b1;
        m[13] = 1'b1;
        m[15] = 1'b1;
        m[18] = 1'b1;
        m[19] = 1'b1;
        m[0]  = (ialign == 32);
        return m;
    endfunction

    // Writable bits of the hypervisor interrupt register: guest
    // software, timer and external interrupts.
    function automatic logic [63:0] hyp_irq_mask();
        logic [63:0] m;
        m = '0;
        m[2]  = 1'b1;
        m[6]  = 1'b1;
        m[10] = 1'b1;
        return m;
    endfunction

    // Guest interrupt numbers sit one above their plain supervisor twins.
    function automatic code_t guest_view_code(input code_t c);
        return c - code_t'(1);
    endfunction

    function automatic tgt_e pick_target(input priv_e p, input logic virt,
                                         input logic m_del, input logic h_del);
        tgt_e t;
        if (p == PRIV_M || p == PRIV_RSV) t = TGT_M;
        else if (!m_del)                  t = TGT_M;
        else if (virt && h_del)           t = TGT_VS;
        else                              t = TGT_HS;
        return t;
    endfunction

endpackage

// File: rtl/trap_deleg_regs.sv
`timescale 1ns/1ps
module trap_deleg_regs
    import trap_deleg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter logic [NUM_DREG-1:0][XLEN-1:0] WMASK = '1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [1:0]                     wr_sel,
    input  logic [XLEN-1:0]                wr_data,
    input  logic [1:0]                     rd_sel,
    output logic [XLEN-1:0]                rd_data,
    output logic [NUM_DREG-1:0][XLEN-1:0]  dq
);

    for (genvar g = 0; g < NUM_DREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                dq[g] <= '0;
            end else if (wr_en && wr_sel == 2'(g)) begin
                dq[g] <= wr_data & WMASK[g];
            end
        end
    end

    assign rd_data = dq[rd_sel];

    // R12: registers move only on a write
    a_r12_hold_without_write: assert property (
        @(posedge clk) disable iff (rst)
        !wr_en |=> $stable(dq)
    );

endmodule

// File: rtl/trap_deleg_pick.sv
`timescale 1ns/1ps
module trap_deleg_pick
    import trap_deleg_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] exc_q,
    input  logic [XLEN-1:0] irq_q,
    input  logic            is_irq,
    input  code_t           code,
    output logic            del
);

    localparam int IDX_W = $clog2(XLEN);

    logic [XLEN-1:0] src;

    always_comb begin
        src = is_irq ? irq_q : exc_q;
        if (code < code_t'(XLEN)) del = src[code[IDX_W-1:0]];
        else                      del = 1'b0;
    end

endmodule

// File: rtl/trap_deleg_route.sv
`timescale 1ns/1ps
module trap_deleg_route
    import trap_deleg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trap_valid,
    input  logic      is_irq,
    input  code_t     code,
    input  priv_e     priv,
    input  logic      virt,
    input  logic      m_del,
    input  logic      h_del,
    output trap_res_t res
);

    tgt_e  tgt_n;
    code_t code_n;

    always_comb begin
        tgt_n  = pick_target(priv, virt, m_del, h_del);
        code_n = (tgt_n == TGT_VS && is_irq) ? guest_view_code(code) : code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res.valid <= 1'b0;
            res.mode  <= TGT_M;
            res.irq   <= 1'b0;
            res.code  <= '0;
        end else begin
            res.valid <= trap_valid;
            if (trap_valid) begin
                res.mode <= tgt_n;
                res.irq  <= is_irq;
                res.code <= code_n;
            end
        end
    end

    // R1: machine-level traps never leave machine mode
    a_r1_machine_stays: assert property (
        @(posedge clk) disable iff (rst)
        (trap_valid && (priv == PRIV_M || priv == PRIV_RSV)) |=> (res.mode == TGT_M)
    );

    // R2: outside a guest nothing reaches VS
    a_r2_no_guest_without_v: assert property (
        @(posedge clk) disable iff (rst)
        (trap_valid && !virt) |=> (res.mode != TGT_VS)
    );

    // R4: the hypervisor stage never acts alone
    a_r4_needs_machine_stage: assert property (
        @(posedge clk) disable iff (rst)
        (trap_valid && !m_del) |=> (res.mode == TGT_M)
    );

    // R8: guest interrupts arrive one number lower
    a_r8_guest_irq_renumber: assert property (
        @(posedge clk) disable iff (rst)
        (trap_valid && is_irq) |=> (res.mode != TGT_VS || res.code == $past(code) - code_t'(1))
    );

    // R10: one result per request, one cycle later
    a_r10_valid_follows: assert property (
        @(posedge clk) disable iff (rst)
        trap_valid |=> res.valid
    );
    a_r10_no_spurious: assert property (
        @(posedge clk) disable iff (rst)
        !trap_valid |=> !res.valid
    );

endmodule

// File: rtl/trap_deleg_resolver.sv
`timescale 1ns/1ps
module trap_deleg_resolver
    import trap_deleg_pkg::*;
#(
    parameter int              XLEN       = 64,
    parameter int              IALIGN     = 32,
    parameter logic [XLEN-1:0] MEXC_WMASK = '1,
    parameter logic [XLEN-1:0] MIRQ_WMASK = '1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         dw_en,
    input  logic [1:0]                   dw_sel,
    input  logic [XLEN-1:0]              dw_data,
    input  logic [1:0]                   rd_sel,
    output logic [XLEN-1:0]              rd_data,
    input  logic                         trap_valid,
    input  logic                         trap_irq,
    input  logic [trap_deleg_pkg::CODE_W-1:0] trap_code,
    input  logic [1:0]                   cur_priv,
    input  logic                         cur_virt,
    output logic                         res_valid,
    output logic [1:0]                   res_mode,
    output logic                         res_irq,
    output logic [trap_deleg_pkg::CODE_W-1:0] res_code
);

    localparam logic [63:0]     HEXC_FULL  = hyp_exc_mask(IALIGN);
    localparam logic [63:0]     HIRQ_FULL  = hyp_irq_mask();
    localparam logic [XLEN-1:0] HEXC_WMASK = HEXC_FULL[XLEN-1:0];
    localparam logic [XLEN-1:0] HIRQ_WMASK = HIRQ_FULL[XLEN-1:0];
    localparam logic [NUM_DREG-1:0][XLEN-1:0] WMASK =
        {HIRQ_WMASK, HEXC_WMASK, MIRQ_WMASK, MEXC_WMASK};
    localparam int NUM_STAGE = NUM_DREG / 2;

    logic [NUM_DREG-1:0][XLEN-1:0] dq;
    logic [NUM_STAGE-1:0]          stage_del;
    trap_res_t                     res;

    trap_deleg_regs #(
        .XLEN  (XLEN),
        .WMASK (WMASK)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dw_en),
        .wr_sel  (dw_sel),
        .wr_data (dw_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .dq      (dq)
    );

    // Stage 0 is the machine level, stage 1 the hypervisor level.
    for (genvar s = 0; s < NUM_STAGE; s++) begin : g_stage
        trap_deleg_pick #(
            .XLEN (XLEN)
        ) u_pick (
            .exc_q  (dq[2*s]),
            .irq_q  (dq[2*s+1]),
            .is_irq (trap_irq),
            .code   (trap_code),
            .del    (stage_del[s])
        );
    end

    trap_deleg_route u_route (
        .clk        (clk),
        .rst        (rst),
        .trap_valid (trap_valid),
        .is_irq     (trap_irq),
        .code       (trap_code),
        .priv       (priv_e'(cur_priv)),
        .virt       (cur_virt),
        .m_del      (stage_del[0]),
        .h_del      (stage_del[1]),
        .res        (res)
    );

    assign res_valid = res.valid;
    assign res_mode  = res.mode;
    assign res_irq   = res.irq;
    assign res_code  = res.code;

    // R5: fixed read-only-zero bits of the hypervisor exception register
    a_r5_hexc_ro_zero: assert property (
        @(posedge clk) disable iff (rst)
        (rd_sel == 2'(SEL_HEXC)) |-> ((rd_data & ~HEXC_WMASK) == '0)
    );

    // R6: only the three guest interrupt bits survive in the hyp irq register
    a_r6_hirq_ro_zero: assert property (
        @(posedge clk) disable iff (rst)
        (rd_sel == 2'(SEL_HIRQ)) |-> ((rd_data & ~HIRQ_WMASK) == '0)
    );

    // R11: out-of-range codes stay in machine mode
    a_r11_wide_code_machine: assert property (
        @(posedge clk) disable iff (rst)
        (trap_valid && trap_code >= code_t'(XLEN)) |=> (res_mode == 2'(TGT_M))
    );

endmodule

// File: tb/trap_deleg_resolver_test.sv
`timescale 1ns/1ps
module trap_deleg_resolver_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dw_en = 1'b0;
    logic [1:0]  dw_sel = '0;
    logic [63:0] dw_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic        trap_valid = 1'b0;
    logic        trap_irq = 1'b0;
    logic [7:0]  trap_code = '0;
    logic [1:0]  cur_priv = '0;
    logic        cur_virt = 1'b0;
    logic        res_valid;
    logic [1:0]  res_mode;
    logic        res_irq;
    logic [7:0]  res_code;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    bit [63:0] sh [4];

    always #2.5 clk = ~clk;

    trap_deleg_resolver uut (
        .clk(clk), .rst(rst),
        .dw_en(dw_en), .dw_sel(dw_sel), .dw_data(dw_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .trap_valid(trap_valid), .trap_irq(trap_irq), .trap_code(trap_code),
        .cur_priv(cur_priv), .cur_virt(cur_virt),
        .res_valid(res_valid), .res_mode(res_mode),
        .res_irq(res_irq), .res_code(res_code)
    );

    function automatic bit [63:0] wmask(input int sel);
        bit [63:0] m;
        m = '0;
        case (sel)
            0, 1: m = '1;                                    // R7
            2: begin                                         // R5
                for (int b = 0; b <= 8; b++) m[b] = 1'b1;
                m[12] = 1'b1; m[13] = 1'b1; m[15] = 1'b1;
                m[18] = 1'b1; m[19] = 1'b1;
            end
            default: begin m[2] = 1'b1; m[6] = 1'b1; m[10] = 1'b1; end  // R6
        endcase
        return m;
    endfunction

    function automatic int exp_mode(input int code, input bit irq, input int priv, input bit virt);
        bit md, hd;
        md = (code < 64) ? (irq ? sh[1][code] : sh[0][code]) : 1'b0;
        hd = (code < 64) ? (irq ? sh[3][code] : sh[2][code]) : 1'b0;
        if (priv >= 2) return 3;
        if (!md) return 3;
        if (virt && hd) return 2;
        return 1;
    endfunction

    task automatic chk(input string req, input string what,
                       input bit [63:0] act, input bit [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int sel, input bit [63:0] d);
        @(negedge clk);
        dw_en = 1'b1; dw_sel = 2'(sel); dw_data = d;
        @(negedge clk);
        dw_en = 1'b0;
        sh[sel] = d & wmask(sel);
    endtask

    task automatic rd_chk(input int sel, input string req);
        @(negedge clk);
        rd_sel = 2'(sel);
        #1;
        chk(req, $sformatf("readback sel %0d", sel), rd_data, sh[sel]);
    endtask

    task automatic trap(input int code, input bit irq, input int priv,
                        input bit virt, input string req);
        int m, c;
        m = exp_mode(code, irq, priv, virt);
        c = (m == 2 && irq) ? code - 1 : code;
        @(negedge clk);
        trap_valid = 1'b1; trap_irq = irq; trap_code = 8'(code);
        cur_priv = 2'(priv); cur_virt = virt;
        @(negedge clk);
        trap_valid = 1'b0;
        chk(req, $sformatf("valid code=%0d irq=%0d", code, irq), 64'(res_valid), 64'd1);
        chk(req, $sformatf("mode code=%0d irq=%0d priv=%0d v=%0d", code, irq, priv, virt),
            64'(res_mode), 64'(m));
        chk(req, $sformatf("cause code=%0d irq=%0d", code, irq), 64'(res_code), 64'(c));
        chk("R9", "irq echo", 64'(res_irq), 64'(irq));
    endtask

    function automatic string auto_tag(input int code, input bit irq, input int priv, input bit virt);
        if (code >= 64) return "R11";
        if (priv >= 2) return "R1";
        if (!virt) return "R2";
        if (irq) return "R8";
        return "R3";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) sh[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        for (int s = 0; s < 4; s++) rd_chk(s, "R10");
        @(negedge clk);
        chk("R10", "reset res_valid", 64'(res_valid), 64'd0);
        chk("R10", "reset res_mode", 64'(res_mode), 64'd3);

        // R12: a write touches only its own register
        wr(1, 64'h0000_0000_0000_0222);
        rd_chk(0, "R12");
        rd_chk(2, "R12");
        rd_chk(1, "R12");

        // R4: hypervisor bit without the machine bit
        wr(2, '1);
        trap(12, 1'b0, 0, 1'b1, "R4");

        // R5/R6/R7: all-ones readback
        for (int s = 0; s < 4; s++) wr(s, '1);
        rd_chk(0, "R7");
        rd_chk(1, "R7");
        rd_chk(2, "R5");
        rd_chk(3, "R6");
        @(negedge clk);
        rd_sel = 2'd2; #1;
        chk("R5", "hexc literal", rd_data, 64'h0000_0000_000C_B1FF);
        rd_sel = 2'd3; #1;
        chk("R6", "hirq literal", rd_data, 64'h0000_0000_0000_0444);

        // Directed routing with every writable bit set
        trap(12, 1'b0, 0, 1'b1, "R9");
        trap(10, 1'b1, 1, 1'b1, "R8");
        trap(6,  1'b1, 1, 1'b1, "R8");
        trap(2,  1'b1, 0, 1'b1, "R8");
        trap(9,  1'b1, 1, 1'b1, "R8");
        trap(10, 1'b1, 1, 1'b0, "R8");
        trap(20, 1'b0, 0, 1'b1, "R5");
        trap(10, 1'b0, 1, 1'b1, "R5");
        trap(22, 1'b0, 1, 1'b1, "R5");
        trap(12, 1'b0, 3, 1'b0, "R1");
        trap(12, 1'b0, 3, 1'b1, "R1");
        trap(5,  1'b0, 2, 1'b0, "R1");
        trap(12, 1'b0, 1, 1'b0, "R2");
        trap(70, 1'b0, 0, 1'b1, "R11");
        trap(64, 1'b1, 1, 1'b1, "R11");
        @(negedge clk);
        chk("R10", "idle res_valid", 64'(res_valid), 64'd0);

        // R4: machine stage cleared, hypervisor stage still set
        wr(0, 64'd0);
        trap(12, 1'b0, 0, 1'b1, "R4");
        trap(10, 1'b1, 1, 1'b1, "R3");

        // Random mix of writes and traps
        for (int i = 0; i < 500; i++) begin
            if ($urandom % 5 == 0) begin
                wr(int'($urandom % 4), {$urandom, $urandom} | ({$urandom, $urandom} & 64'h0000_0000_000F_FFFF));
            end else begin
                int code, priv;
                bit irq, virt;
                irq  = 1'($urandom % 2);
                code = ($urandom % 16 == 0) ? 64 + int'($urandom % 40)
                                            : int'($urandom % (irq ? 14 : 24));
                priv = int'($urandom % 4);
                if (priv == 2 && $urandom % 2 == 0) priv = 1;
                virt = 1'($urandom % 2);
                trap(code, irq, priv, virt, auto_tag(code, irq, priv, virt));
            end
        end
        for (int s = 0; s < 4; s++) rd_chk(s, "R12");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule